// File: doc/BRIEF.md
# Parallel Port Interrupt Status Unit

This unit sits beside the peripheral-side controller of an IEEE 1284 parallel port. It gathers the port's interrupt events and latches each one into its own bit of an 8-bit sticky status register. An 8-bit enable register uses the same bit positions and decides which latched events drive a single active-high interrupt request. Some events arrive as one-cycle strobes from the port's negotiation, EPP and direction logic. Others the unit detects itself: it watches the asynchronous, active-low host initialise line and a set of monitored handshake lines. Both of these are resynchronised through a configurable flop chain before detection.

Two of the sources depend on the port's operating mode. The initialise event counts only in compatibility mode. The handshake-match event counts only in manual mode, and once latched it stays set after manual mode ends. Software reads and writes the registers through a plain register bus with no handshake: reads are combinational and writes take effect on the clock edge. Any write to the status register clears every pending bit, whatever the data. An event that arrives in the same cycle as that write still leaves its bit set. Every pin is a plain control or status signal, and the unit moves no data stream, so it has no valid/ready interfaces and applies no back-pressure.

Top module: `ppirq_unit`

## Requirements
- R1: After reset the enable register, the status register and the EPP address register all read 0x00, and `irq` is low.
- R2: `irq` is high exactly when some status bit and its enable bit are both 1. A status bit latches even when its enable bit is 0.
- R3: A write to address 1 (status) clears every status bit, whatever the write data.
- R4: If an event occurs in the same cycle as a status clear, the event's status bit reads 1 after that cycle.
- R5: Status bit 0 sets on a falling edge of the synchronised `ninit_n`, and only if `compat_mode` is high. Holding `ninit_n` low does not set the bit again after a clear.
- R6: Status bit 4 sets when the condition "`manual_mode` high and any line is low with its `zero_mask` bit set, or high with its `one_mask` bit set" goes from false to true. The condition is evaluated on synchronised lines. While `manual_mode` is low, handshake changes do not set bit 4.
- R7: A pending bit 4 stays set when `manual_mode` falls. Only a status clear removes it.
- R8: `epp_addr_evt` sets status bit 3. In the same edge it captures `epp_addr_in` into the EPP address register, which reads at address 2.
- R9: `dir_rev_evt` sets status bit 2, `neg_chg_evt` sets status bit 5, and `id_req_evt` sets status bit 1.
- R10: Bits 7 and 6 of the enable and status registers always read 0. Writing ones to them has no effect.
- R11: A write to address 0 loads the enable register (bits 5..0), and the value reads back at address 0. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 enable, 1 status, 2 EPP address, 3 spare |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from `reg_addr`) |
| compat_mode | input | 1 | Port is in compatibility mode |
| manual_mode | input | 1 | Port is in manual mode |
| ninit_n | input | 1 | Host initialise line, asynchronous, active low |
| hs_in | input | NSIG | Monitored handshake lines, asynchronous |
| zero_mask | input | NSIG | Lines whose low level counts as a match |
| one_mask | input | NSIG | Lines whose high level counts as a match |
| neg_chg_evt | input | 1 | Negotiation status changed (strobe) |
| id_req_evt | input | 1 | Host requested the ID string (strobe) |
| dir_rev_evt | input | 1 | Host completed a direction reversal (strobe) |
| epp_addr_evt | input | 1 | Host wrote an EPP address (strobe) |
| epp_addr_in | input | 8 | EPP address byte captured with `epp_addr_evt` |
| irq | output | 1 | Interrupt request, active high |

## Verification
The table-driven part of the bench fires the four strobe sources alone and all together. Each firing uses a different enable pattern, including all-zero and all-one enables. This separates the latching of a status bit from its gating onto `irq`, and it shows that each strobe lands on its own bit position. Directed runs then hold `ninit_n` and the handshake lines at match levels with the mode flags set both ways. These runs tell a mode-qualified edge apart from a plain level and show that bit 4 outlives manual mode. One run fires an event in the same cycle as a clear write, and another clears with all-zero write data. Together they separate "clear wins" from "event wins" and rule out a data-dependent clear.

// File: rtl/ppirq_pkg.sv
package ppirq_pkg;

  localparam int REG_W = 8;

  // Status / enable bit positions (shared layout)
  localparam int B_NINIT  = 0;
  localparam int B_IDREQ  = 1;
  localparam int B_DIRREV = 2;
  localparam int B_EPPAW  = 3;
  localparam int B_SIGCHG = 4;
  localparam int B_NEGCHG = 5;
  localparam int N_LIVE   = 6;

  localparam logic [REG_W-1:0] LIVE_MASK = REG_W'((1 << N_LIVE) - 1);

  typedef enum logic [1:0] {
    A_ENABLE = 2'd0,
    A_STATUS = 2'd1,
    A_EPPADR = 2'd2,
    A_SPARE  = 2'd3
  } reg_addr_e;

  // Packed so that field i lands on status bit i
  typedef struct packed {
    logic neg_chg;
    logic sig_chg;
    logic epp_aw;
    logic dir_rev;
    logic id_req;
    logic ninit;
  } evt_t;

endpackage

// File: rtl/ppirq_sync.sv
module ppirq_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {NS{{W{RST_VAL}}}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < NS; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[NS-1];
endmodule

// File: rtl/ppirq_detect.sv
module ppirq_detect #(
  parameter int NSIG = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            compat_mode,
  input  logic            manual_mode,
  input  logic            ninit_s,
  input  logic [NSIG-1:0] hs_s,
  input  logic [NSIG-1:0] zero_mask,
  input  logic [NSIG-1:0] one_mask,
  output logic            ninit_evt,
  output logic            sig_evt
);
  logic            ninit_prev;
  logic            qual_prev;
  logic [NSIG-1:0] line_hit;
  logic            qual_now;

  // Per-line match against its programmed level
  for (genvar g = 0; g < NSIG; g++) begin : g_line
    assign line_hit[g] = (zero_mask[g] & ~hs_s[g]) | (one_mask[g] & hs_s[g]);
  end

  assign qual_now = manual_mode & (|line_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ninit_prev <= 1'b1;
      qual_prev  <= 1'b0;
    end else begin
      ninit_prev <= ninit_s;
      qual_prev  <= qual_now;
    end
  end

  assign ninit_evt = compat_mode & ninit_prev & ~ninit_s;
  assign sig_evt   = qual_now & ~qual_prev;
endmodule

// File: rtl/ppirq_regs.sv
module ppirq_regs
  import ppirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] set_vec,
  input  logic             epp_evt,
  input  logic [REG_W-1:0] epp_data,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] enable_q,
  output logic [REG_W-1:0] status_q,
  output logic [REG_W-1:0] epp_q
);
  reg_addr_e a;
  logic      clr;

  assign a   = reg_addr_e'(addr);
  assign clr = wr && (a == A_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      status_q <= '0;
      epp_q    <= '0;
    end else begin
      if (wr && (a == A_ENABLE)) enable_q <= wdata & LIVE_MASK;
      // New events take precedence over a clear in the same cycle
      if (clr) status_q <= set_vec & LIVE_MASK;
      else     status_q <= (status_q | set_vec) & LIVE_MASK;
      if (epp_evt) epp_q <= epp_data;
    end
  end

  always_comb begin
    unique case (a)
      A_ENABLE: rdata = enable_q;
      A_STATUS: rdata = status_q;
      A_EPPADR: rdata = epp_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/ppirq_unit.sv
module ppirq_unit
  import ppirq_pkg::*;
#(
  parameter int NSIG = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             compat_mode,
  input  logic             manual_mode,
  input  logic             ninit_n,
  input  logic [NSIG-1:0]  hs_in,
  input  logic [NSIG-1:0]  zero_mask,
  input  logic [NSIG-1:0]  one_mask,
  input  logic             neg_chg_evt,
  input  logic             id_req_evt,
  input  logic             dir_rev_evt,
  input  logic             epp_addr_evt,
  input  logic [REG_W-1:0] epp_addr_in,
  output logic             irq
);
  localparam int PAD = REG_W - N_LIVE;

  logic             ninit_s;
  logic [NSIG-1:0]  hs_s;
  logic             ninit_evt;
  logic             sig_evt;
  evt_t             evt;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] enable_q;
  logic [REG_W-1:0] status_q;
  logic [REG_W-1:0] epp_q;

  ppirq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_init (
    .clk(clk), .rst_n(rst_n), .d(ninit_n), .q(ninit_s)
  );

  ppirq_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_hs (
    .clk(clk), .rst_n(rst_n), .d(hs_in), .q(hs_s)
  );

  ppirq_detect #(.NSIG(NSIG)) u_detect (
    .clk(clk), .rst_n(rst_n),
    .compat_mode(compat_mode), .manual_mode(manual_mode),
    .ninit_s(ninit_s), .hs_s(hs_s),
    .zero_mask(zero_mask), .one_mask(one_mask),
    .ninit_evt(ninit_evt), .sig_evt(sig_evt)
  );

  always_comb begin
    evt.ninit   = ninit_evt;
    evt.id_req  = id_req_evt;
    evt.dir_rev = dir_rev_evt;
    evt.epp_aw  = epp_addr_evt;
    evt.sig_chg = sig_evt;
    evt.neg_chg = neg_chg_evt;
  end

  assign set_vec = {{PAD{1'b0}}, evt};

  ppirq_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .set_vec(set_vec),
    .epp_evt(epp_addr_evt), .epp_data(epp_addr_in),
    .rdata(reg_rdata),
    .enable_q(enable_q), .status_q(status_q), .epp_q(epp_q)
  );

  assign irq = |(status_q & enable_q);
endmodule

// File: rtl/ppirq_chk.sv
module ppirq_chk
  import ppirq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic             compat_mode,
  input logic             manual_mode,
  input logic             neg_chg_evt,
  input logic             epp_addr_evt,
  input logic [REG_W-1:0] epp_addr_in,
  input logic             irq,
  input logic [REG_W-1:0] status_q,
  input logic [REG_W-1:0] enable_q,
  input logic [REG_W-1:0] epp_q
);
  logic clr_wr;
  assign clr_wr = reg_wr && (reg_addr == 2'd1);

  // R2
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status_q & enable_q) != '0));

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !neg_chg_evt) |=> !status_q[B_NEGCHG]);

  // R4
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    neg_chg_evt |=> status_q[B_NEGCHG]);

  // R5
  ninit_needs_compat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[B_NINIT]) |-> $past(compat_mode));

  // R6
  sigchg_needs_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[B_SIGCHG]) |-> $past(manual_mode));

  // R7
  sigchg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[B_SIGCHG] && !clr_wr) |=> status_q[B_SIGCHG]);

  // R8
  epp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epp_addr_evt |=> (epp_q == $past(epp_addr_in)) && status_q[B_EPPAW]);

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[REG_W-1:N_LIVE] == '0) && (enable_q[REG_W-1:N_LIVE] == '0));
endmodule

bind ppirq_unit ppirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .compat_mode(compat_mode), .manual_mode(manual_mode),
  .neg_chg_evt(neg_chg_evt), .epp_addr_evt(epp_addr_evt),
  .epp_addr_in(epp_addr_in), .irq(irq),
  .status_q(status_q), .enable_q(enable_q), .epp_q(epp_q)
);

// File: tb/ppirq_unit_test.sv
module ppirq_unit_test;
  localparam int NSIG = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0;
  logic [1:0]      reg_addr = 2'd0;
  logic [7:0]      reg_wdata = 8'h00;
  logic [7:0]      reg_rdata;
  logic            compat_mode = 1'b0;
  logic            manual_mode = 1'b0;
  logic            ninit_n = 1'b1;
  logic [NSIG-1:0] hs_in = '1;
  logic [NSIG-1:0] zero_mask = '0;
  logic [NSIG-1:0] one_mask = '0;
  logic            neg_chg_evt = 1'b0;
  logic            id_req_evt = 1'b0;
  logic            dir_rev_evt = 1'b0;
  logic            epp_addr_evt = 1'b0;
  logic [7:0]      epp_addr_in = 8'h00;
  logic            irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ppirq_unit #(.NSIG(NSIG), .SYNC_STAGES(2)) uut (.*);

  // {strobes[3:0] = neg,epp,dir,id ; enable ; expected status ; expected irq}
  localparam logic [20:0] VEC [0:5] = '{
    {4'b0001, 8'h00, 8'h02, 1'b0},
    {4'b0010, 8'h04, 8'h04, 1'b1},
    {4'b0100, 8'h02, 8'h08, 1'b0},
    {4'b1000, 8'hFF, 8'h20, 1'b1},
    {4'b1111, 8'h08, 8'h2E, 1'b1},
    {4'b0000, 8'hFF, 8'h00, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(2'd0, v); check("R1 enable", v, 8'h00);
    rd(2'd1, v); check("R1 status", v, 8'h00);
    rd(2'd2, v); check("R1 eppadr", v, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // Table: R2 gating, R9 strobe bit positions
    for (int k = 0; k < 6; k++) begin
      wr(2'd1, 8'h00);
      wr(2'd0, VEC[k][16:9]);
      @(negedge clk);
      id_req_evt   = VEC[k][17];
      dir_rev_evt  = VEC[k][18];
      epp_addr_evt = VEC[k][19];
      neg_chg_evt  = VEC[k][20];
      epp_addr_in  = 8'h3C;
      @(negedge clk);
      {id_req_evt, dir_rev_evt, epp_addr_evt, neg_chg_evt} = 4'b0000;
      rd(2'd1, v); check($sformatf("R9 status vec%0d", k), v, VEC[k][8:1]);
      check($sformatf("R2 irq vec%0d", k), {7'd0, irq}, {7'd0, VEC[k][0]});
    end

    // R10 reserved bits / R11 enable readback and spare address
    wr(2'd0, 8'hFF);
    rd(2'd0, v); check("R10 enable reserved", v, 8'h3F);
    wr(2'd0, 8'h15);
    rd(2'd0, v); check("R11 enable readback", v, 8'h15);
    rd(2'd3, v); check("R11 spare addr", v, 8'h00);
    wr(2'd0, 8'hFF);

    // R8 EPP capture
    wr(2'd1, 8'h00);
    @(negedge clk); epp_addr_evt = 1'b1; epp_addr_in = 8'hA5;
    @(negedge clk); epp_addr_evt = 1'b0; epp_addr_in = 8'h00;
    rd(2'd2, v); check("R8 eppadr", v, 8'hA5);
    rd(2'd1, v); check("R8 status", v, 8'h08);

    // R3 clear with zero data
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R3 cleared", v, 8'h00);
    check("R3 irq low", {7'd0, irq}, 8'h00);

    // R4 event in same cycle as clear
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'hFF; neg_chg_evt = 1'b1;
    @(negedge clk); reg_wr = 1'b0; neg_chg_evt = 1'b0;
    rd(2'd1, v); check("R4 event wins", v, 8'h20);
    wr(2'd1, 8'h00);

    // R5 nINIT in compat mode
    compat_mode = 1'b1;
    @(negedge clk); ninit_n = 1'b0;
    idle(4);
    rd(2'd1, v); check("R5 ninit compat", v, 8'h01);
    wr(2'd1, 8'h00);
    idle(4);
    rd(2'd1, v); check("R5 held low no reset", v, 8'h00);
    ninit_n = 1'b1; idle(4);
    compat_mode = 1'b0;
    ninit_n = 1'b0; idle(4);
    rd(2'd1, v); check("R5 ninit not compat", v, 8'h00);
    ninit_n = 1'b1; idle(4);

    // R6 signal change only in manual mode
    zero_mask = 5'b00001; one_mask = 5'b00000; hs_in = 5'b11111;
    idle(4);
    hs_in[0] = 1'b0; idle(4);
    rd(2'd1, v); check("R6 no manual", v, 8'h00);
    hs_in[0] = 1'b1; idle(4);
    manual_mode = 1'b1; idle(2);
    hs_in[0] = 1'b0; idle(4);
    rd(2'd1, v); check("R6 zero match", v, 8'h10);
    // R7 sticky past manual mode
    manual_mode = 1'b0; idle(3);
    rd(2'd1, v); check("R7 survives exit", v, 8'h10);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R7 cleared by write", v, 8'h00);
    // R6 one-detect mask
    hs_in = 5'b11111; zero_mask = '0; one_mask = 5'b00010; idle(1);
    hs_in[1] = 1'b0; idle(3);
    manual_mode = 1'b1; idle(2);
    hs_in[1] = 1'b1; idle(4);
    rd(2'd1, v); check("R6 one match", v, 8'h10);
    manual_mode = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule